// File: doc/BRIEF.md
# Eight-Bit Signed Arithmetic and Logic Unit

This block is a purely combinational arithmetic/logic unit for two 8-bit two's-complement operands. A 4-bit select picks one of ten functions: sum, difference in either direction, bitwise OR/AND/XOR, the bitwise inverse of either operand, and the arithmetic negation of either operand. The result settles from the inputs with no clock edge, together with signed-overflow, carry and zero status.

Alongside every result the unit reports how the two operands relate as signed numbers: greater, less or equal. This lets a datapath compute a value and branch on the operand relation in the same step. A decoder turns the select into a small set of strobes that steer a shared ripple adder and a logic unit. A separate comparator produces the relation flags.

Top module: `alu8_top`

## Requirements
- R1: Select code 0 gives result = (A + B) mod 256.
- R2: Select code 1 gives (A − B) mod 256 and select code 2 gives (B − A) mod 256.
- R3: Select codes 3, 4 and 5 give the bitwise OR, AND and XOR of A and B.
- R4: Select code 6 gives the bitwise inverse of A and code 7 gives the bitwise inverse of B.
- R5: Select codes 8 and 9 give the two's-complement negation of A and of B (inverse plus one). Negating −128 (0x80) yields 0x80 with overflow high.
- R6: Select codes 10 to 15 drive result to 0, overflow and carry to 0, and zero to 1, whatever the operands are.
- R7: overflow is 1 exactly when the signed result of codes 0, 1, 2, 8 or 9 lies outside −128..127. It is 0 for codes 3 to 7.
- R8: carry is the ninth adder bit. For code 0 it is 1 when A + B > 255 as unsigned values. For code 1 it is 1 when A ≥ B unsigned, and for code 2 when B ≥ A unsigned. For code 8 it is 1 when A = 0, and for code 9 when B = 0. It is 0 for codes 3 to 7.
- R9: zero is 1 exactly when the 8-bit result equals 0.
- R10: aGtB, aLtB and aEqB compare A and B as signed values for every select code. Exactly one of them is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 8 | Operand A, two's complement |
| opB | input | 8 | Operand B, two's complement |
| opSel | input | 4 | Function select, codes 0 to 9 valid |
| result | output | 8 | Function result |
| overflow | output | 1 | Signed overflow of arithmetic functions |
| carry | output | 1 | Ninth bit of the adder path |
| zero | output | 1 | Result equals zero |
| aGtB | output | 1 | A greater than B (signed) |
| aLtB | output | 1 | A less than B (signed) |
| aEqB | output | 1 | A equal to B (signed) |

## Verification
Every one of the sixteen select codes is driven with all 65,536 operand pairs. Every output is compared with a behavioural integer model. The full sweep reaches the two signed-range edges where sums and differences wrap: operands mixing 0x7F, 0x80, 0x00 and 0xFF. These pairs separate a correct overflow from one derived from the unsigned carry, and a borrow-style carry from a true ninth bit. The same sweep runs under the unused codes, which shows that the operands never leak into the result there. Running the relation flags under every select shows that they depend on the operands alone. Pairs with opposite signs show the compare is signed and not unsigned.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_RSUB = 4'd2,
    OP_OR   = 4'd3,
    OP_AND  = 4'd4,
    OP_XOR  = 4'd5,
    OP_NOTA = 4'd6,
    OP_NOTB = 4'd7,
    OP_NEGA = 4'd8,
    OP_NEGB = 4'd9
  } opcode_e;

  typedef enum logic [1:0] {X_A, X_NOTA, X_ZERO} xsel_e;
  typedef enum logic [1:0] {Y_B, Y_NOTB, Y_ZERO} ysel_e;
  typedef enum logic [2:0] {L_OR, L_AND, L_XOR, L_NOTA, L_NOTB} logicfn_e;
  typedef enum logic [1:0] {R_ARITH, R_LOGIC, R_NONE} rsel_e;

  typedef struct packed {
    xsel_e    xSel;
    ysel_e    ySel;
    logic     carryIn;
    logicfn_e logicFn;
    rsel_e    resultSel;
  } alu_strobe_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [3:0]  opSel,
  output alu_strobe_t strobes
);

  always_comb begin
    strobes = '{xSel: X_A, ySel: Y_B, carryIn: 1'b0, logicFn: L_OR, resultSel: R_NONE};
    case (opSel)
      OP_ADD:  strobes.resultSel = R_ARITH;
      OP_SUB: begin
        strobes.ySel      = Y_NOTB;
        strobes.carryIn   = 1'b1;
        strobes.resultSel = R_ARITH;
      end
      OP_RSUB: begin
        strobes.xSel      = X_NOTA;
        strobes.carryIn   = 1'b1;
        strobes.resultSel = R_ARITH;
      end
      OP_NEGA: begin
        strobes.xSel      = X_NOTA;
        strobes.ySel      = Y_ZERO;
        strobes.carryIn   = 1'b1;
        strobes.resultSel = R_ARITH;
      end
      OP_NEGB: begin
        strobes.xSel      = X_ZERO;
        strobes.ySel      = Y_NOTB;
        strobes.carryIn   = 1'b1;
        strobes.resultSel = R_ARITH;
      end
      OP_OR:   begin strobes.logicFn = L_OR;   strobes.resultSel = R_LOGIC; end
      OP_AND:  begin strobes.logicFn = L_AND;  strobes.resultSel = R_LOGIC; end
      OP_XOR:  begin strobes.logicFn = L_XOR;  strobes.resultSel = R_LOGIC; end
      OP_NOTA: begin strobes.logicFn = L_NOTA; strobes.resultSel = R_LOGIC; end
      OP_NOTB: begin strobes.logicFn = L_NOTB; strobes.resultSel = R_LOGIC; end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  alu_strobe_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             overflow,
  output logic             carry,
  output logic             zero
);

  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] MIN_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] xOp, yOp, sumBits, logicRes;
  logic [WIDTH:0]   chain;
  logic             arithOvf;

  always_comb begin
    case (strobes.xSel)
      X_NOTA:  xOp = ~opA;
      X_ZERO:  xOp = '0;
      default: xOp = opA;
    endcase
    case (strobes.ySel)
      Y_NOTB:  yOp = ~opB;
      Y_ZERO:  yOp = '0;
      default: yOp = opB;
    endcase
  end

  assign chain[0] = strobes.carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_ripple
    assign sumBits[i]  = xOp[i] ^ yOp[i] ^ chain[i];
    assign chain[i+1]  = (xOp[i] & yOp[i]) | (chain[i] & (xOp[i] ^ yOp[i]));
  end

  assign arithOvf = chain[WIDTH] ^ chain[WIDTH-1];

  always_comb begin
    case (strobes.logicFn)
      L_AND:   logicRes = opA & opB;
      L_XOR:   logicRes = opA ^ opB;
      L_NOTA:  logicRes = ~opA;
      L_NOTB:  logicRes = ~opB;
      default: logicRes = opA | opB;
    endcase
  end

  always_comb begin
    case (strobes.resultSel)
      R_ARITH: begin
        result   = sumBits;
        overflow = arithOvf;
        carry    = chain[WIDTH];
      end
      R_LOGIC: begin
        result   = logicRes;
        overflow = 1'b0;
        carry    = 1'b0;
      end
      default: begin
        result   = '0;
        overflow = 1'b0;
        carry    = 1'b0;
      end
    endcase

    if (strobes.resultSel == R_ARITH && strobes.xSel == X_A && strobes.ySel == Y_B && !strobes.carryIn)
      AST_ADD_WIDE: assert ({carry, result} == ({1'b0, opA} + {1'b0, opB}))
        else $error("wide add mismatch"); // R1
    if (strobes.resultSel == R_ARITH && strobes.xSel == X_NOTA && strobes.ySel == Y_ZERO && opA == MIN_NEG)
      AST_NEG_MIN: assert (overflow && result == MIN_NEG)
        else $error("negating minimum value"); // R5
    if (strobes.resultSel == R_ARITH && strobes.xSel == X_A && strobes.ySel == Y_NOTB)
      AST_SUB_OVF: assert (overflow == ((opA[MSB] != opB[MSB]) && (result[MSB] != opA[MSB])))
        else $error("subtract overflow"); // R7
    if (strobes.resultSel != R_ARITH)
      AST_NO_OVERFLOW: assert (!overflow && !carry)
        else $error("status on non-arith"); // R7
  end

  assign zero = ~|result;

endmodule

// File: rtl/alu8_compare.sv
module alu8_compare #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             aGtB,
  output logic             aLtB,
  output logic             aEqB
);

  always_comb begin
    aEqB = (opA == opB);
    aGtB = ($signed(opA) > $signed(opB));
    aLtB = ($signed(opA) < $signed(opB));
  end

endmodule

// File: rtl/alu8_top.sv
module alu8_top
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       opSel,
  output logic [WIDTH-1:0] result,
  output logic             overflow,
  output logic             carry,
  output logic             zero,
  output logic             aGtB,
  output logic             aLtB,
  output logic             aEqB
);

  alu_strobe_t strobes;

  alu8_ctrl ctrl_i (
    .opSel   (opSel),
    .strobes (strobes)
  );

  alu8_datapath #(.WIDTH(WIDTH)) dp_i (
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .result   (result),
    .overflow (overflow),
    .carry    (carry),
    .zero     (zero)
  );

  alu8_compare #(.WIDTH(WIDTH)) cmp_i (
    .opA  (opA),
    .opB  (opB),
    .aGtB (aGtB),
    .aLtB (aLtB),
    .aEqB (aEqB)
  );

  always_comb begin
    AST_ONE_RELATION: assert ($countones({aGtB, aLtB, aEqB}) == 1)
      else $error("relation flags not one-hot"); // R10
    if (opSel >= 4'd10)
      AST_UNUSED_SEL: assert (result == '0 && zero && !overflow && !carry)
        else $error("unused select leaked"); // R6
  end

endmodule

// File: tb/alu8_top_tb_top.sv
`timescale 1ns/1ps
module alu8_top_tb_top;

  logic       clk = 1'b0;
  logic [7:0] opA = 8'd0, opB = 8'd0;
  logic [3:0] opSel = 4'd0;
  logic [7:0] result;
  logic       overflow, carry, zero, aGtB, aLtB, aEqB;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  alu8_top dut_i (
    .opA(opA), .opB(opB), .opSel(opSel), .result(result),
    .overflow(overflow), .carry(carry), .zero(zero),
    .aGtB(aGtB), .aLtB(aLtB), .aEqB(aEqB)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s op=%0d a=%0h b=%0h actual=%0h expected=%0h", tag, opSel, opA, opB, act, exp);
    end
  endtask

  task automatic checkVector(input int op, input int a, input int b);
    int sa, sb, r, res, ovf, cy;
    string rtag;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    r = 0; ovf = 0; cy = 0;
    case (op)
      0: begin r = sa + sb; cy = ((a + b) > 255) ? 1 : 0; rtag = "R1"; end
      1: begin r = sa - sb; cy = (a >= b) ? 1 : 0; rtag = "R2"; end
      2: begin r = sb - sa; cy = (b >= a) ? 1 : 0; rtag = "R2"; end
      3: begin r = a | b; rtag = "R3"; end
      4: begin r = a & b; rtag = "R3"; end
      5: begin r = a ^ b; rtag = "R3"; end
      6: begin r = 255 - a; rtag = "R4"; end
      7: begin r = 255 - b; rtag = "R4"; end
      8: begin r = -sa; cy = (a == 0) ? 1 : 0; rtag = "R5"; end
      9: begin r = -sb; cy = (b == 0) ? 1 : 0; rtag = "R5"; end
      default: begin r = 0; rtag = "R6"; end
    endcase
    if (op <= 2 || op == 8 || op == 9) ovf = (r > 127 || r < -128) ? 1 : 0;
    res = r & 255;
    chk(rtag,  int'(result),   res);
    chk("R7",  int'(overflow), ovf);
    chk("R8",  int'(carry),    cy);
    chk("R9",  int'(zero),     (res == 0) ? 1 : 0);
    chk("R10", int'(aGtB),     (sa > sb) ? 1 : 0);
    chk("R10", int'(aLtB),     (sa < sb) ? 1 : 0);
    chk("R10", int'(aEqB),     (sa == sb) ? 1 : 0);
  endtask

  initial begin
    #1;
    // Initial operand state: add of zeros
    checkVector(0, 0, 0);
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          opSel = op[3:0];
          opA = a[7:0];
          opB = b[7:0];
          #0.05;
          checkVector(op, a, b);
          #0.05;
        end
      end
    end
    // R5 minimum-value corner explicitly
    opSel = 4'd8; opA = 8'h80; opB = 8'h00;
    #0.05;
    chk("R5", int'(result), 8'h80);
    chk("R5", int'(overflow), 1);
    #0.05;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule